// File: doc/BRIEF.md
# Passive Serial Configuration Master

This block loads a configuration bitstream into a target device over a passive-serial link. After a start pulse, it holds the target's active-low reset-request line low for a timed interval and then releases it. It then waits for the target's open-drain status line to rise. Once the status line is high, it takes configuration bytes from an upstream ready/valid byte stream and shifts each byte out least-significant bit first. It uses one serial-clock period per bit.

The final byte is marked by a last flag on the stream. After that byte, the block waits for the target's open-drain done line. When the done line rises, the block supplies a fixed number of start-up clock pulses so the target can finish initialization. It then reports success. If the status line drops during loading or initialization, the block flags an error and restarts from the reset pulse. If the status line or the done line never arrives, the block gives up with an error.

The block is driven from the system clock. The serial clock and the start-up clock are both divided down from it. The status and done lines pass through two-flop synchronizers before any decision uses them.

Top module: `ps_cfg_master`

## Requirements
- R1: After `start_i` is accepted in idle, `cfg_nrst_o` is held low for exactly RST_CYC system cycles, where RST_CYC = (CLK_FREQ_HZ/1e6)*RST_US (8000 at the defaults, i.e. 40 us at 200 MHz). It is then driven high.
- R2: No rising edge of `cfg_sclk_o` occurs unless the status line is high. While the block waits for the status line, the serial clock stays low.
- R3: Each serial-clock period carries exactly one bit. The low phase lasts DIV_HALF system cycles and the high phase lasts DIV_HALF system cycles. `cfg_data_o` changes only while the serial clock is low, so it is stable across every rising edge.
- R4: Each byte is shifted out least-significant bit first, and bytes go out in stream order.
- R5: `s_ready_o` is high only while loading with an empty shifter and the status line high. A byte transfers on a cycle with `s_valid_i` and `s_ready_o` both high. While no byte is available, `cfg_sclk_o` stays low.
- R6: After the final bit of the byte flagged `s_last_i`, the block waits for the done line. It then produces exactly INIT_CLKS (299) rising edges on `usr_clk_o`, returns to idle with `busy_o` low, and sets `done_o`.
- R7: If the status line is seen low while loading, while waiting for done, or during start-up clocking, the block sets `err_o` and starts a new attempt with the reset pulse of R1. `err_o` then stays high until the next `start_i`.
- R8: If the status line does not rise within STAT_TIMEOUT cycles after the reset request is released, the block sets `err_o` and returns to idle.
- R9: If the done line does not rise within DONE_TIMEOUT cycles after the final bit, the block sets `err_o` and returns to idle with `done_o` low.
- R10: After reset, the outputs are as follows: `cfg_nrst_o` high; `cfg_sclk_o`, `usr_clk_o`, `busy_o`, `done_o`, `err_o` and `s_ready_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a configuration attempt (accepted only in idle) |
| s_data_i | input | 8 | Configuration byte from the upstream stream |
| s_valid_i | input | 1 | Upstream byte valid |
| s_last_i | input | 1 | Marks the final byte of the bitstream |
| s_ready_o | output | 1 | Block can take a byte this cycle |
| cfg_nrst_o | output | 1 | Active-low reset request to the target |
| cfg_sclk_o | output | 1 | Serial configuration clock |
| cfg_data_o | output | 1 | Serial configuration data |
| stat_i | input | 1 | Target status line (open-drain, asynchronous) |
| done_i | input | 1 | Target done line (open-drain, asynchronous) |
| usr_clk_o | output | 1 | Start-up clock for the target's initialization |
| busy_o | output | 1 | An attempt is in progress |
| done_o | output | 1 | The last attempt completed successfully |
| err_o | output | 1 | An error was seen since the last start |

## Verification
The bench attacks the following corner cases:

- **Reset-pulse length.** The bench checks the exact width of the reset pulse. A counter that is off by one would shorten the pulse below the required minimum.
- **Idle periods in the stream.** The bench leaves gaps between bytes. A design that let the serial clock run without data would clock stale bits into the target.
- **Bit order.** A scoreboard reassembles every byte from the serial edges. A reversed shifter would deliver mirrored bytes.
- **Start-up clock count.** The bench counts the start-up clock pulses exactly. Stopping one pulse early or late leaves the target short of, or beyond, initialization.
- **Missing responses.** The bench withholds the status line in one run and the done line in another. A design without timeouts would hang busy forever.
- **Status drop during start-up clocking.** The bench pulls the status line low in this phase. The design must restart with a fresh reset pulse and keep the error flag through the second, successful attempt.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RST   = 3'd1,
        ST_WSTAT = 3'd2,
        ST_LOAD  = 3'd3,
        ST_WDONE = 3'd4,
        ST_INIT  = 3'd5
    } ps_state_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/ps_sync.sv
module ps_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= async_i;
            s2_q <= s1_q;
        end
    end

    assign sync_o = s2_q;
endmodule

// File: rtl/ps_half_tick.sv
module ps_half_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick_o = en_i && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i || tick_o) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
    import ps_cfg_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ  = 200_000_000,
    parameter int unsigned RST_US       = 40,
    parameter int          DIV_HALF     = 2,
    parameter int unsigned INIT_CLKS    = 299,
    parameter int unsigned STAT_TIMEOUT = 100_000,
    parameter int unsigned DONE_TIMEOUT = 100_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] s_data_i,
    input  logic       s_valid_i,
    input  logic       s_last_i,
    output logic       s_ready_o,
    output logic       cfg_nrst_o,
    output logic       cfg_sclk_o,
    output logic       cfg_data_o,
    input  logic       stat_i,
    input  logic       done_i,
    output logic       usr_clk_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o
);
    localparam int unsigned CYC_PER_US = CLK_FREQ_HZ / 1_000_000;
    localparam int unsigned RST_RAW    = CYC_PER_US * RST_US;
    localparam int unsigned RST_CYC    = (RST_RAW == 0) ? 1 : RST_RAW;
    localparam int unsigned M1 = (RST_CYC > STAT_TIMEOUT) ? RST_CYC : STAT_TIMEOUT;
    localparam int unsigned M2 = (M1 > DONE_TIMEOUT) ? M1 : DONE_TIMEOUT;
    localparam int unsigned M3 = (M2 > INIT_CLKS) ? M2 : INIT_CLKS;
    localparam int          CW = $clog2(M3 + 1);
    localparam int          BW = $clog2(BYTE_W + 1);

    localparam logic [CW-1:0] RST_LAST  = CW'(RST_CYC - 1);
    localparam logic [CW-1:0] STAT_LAST = CW'(STAT_TIMEOUT - 1);
    localparam logic [CW-1:0] DONE_LAST = CW'(DONE_TIMEOUT - 1);
    localparam logic [CW-1:0] INIT_N    = CW'(INIT_CLKS);
    localparam logic [BW-1:0] BITS_FULL = BW'(BYTE_W);
    localparam logic [BW-1:0] BITS_ONE  = BW'(1);

    typedef struct packed {
        ps_state_e          st;
        logic [CW-1:0]      cnt;
        logic [BYTE_W-1:0]  sh;
        logic [BW-1:0]      bits;
        logic               last;
        logic               nrst;
        logic               sclk;
        logic               data;
        logic               usr;
        logic               done;
        logic               err;
    } ps_regs_t;

    localparam ps_regs_t REGS_RST = '{
        st: ST_IDLE, cnt: '0, sh: '0, bits: '0, last: 1'b0,
        nrst: 1'b1, sclk: 1'b0, data: 1'b0, usr: 1'b0,
        done: 1'b0, err: 1'b0
    };

    ps_regs_t r_d, r_q;

    logic stat_s, done_s, tick, tick_en, lost;

    ps_sync #(.WIDTH(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({done_i, stat_i}),
        .sync_o  ({done_s, stat_s})
    );

    assign tick_en = ((r_q.st == ST_LOAD) && (r_q.bits != '0)) || (r_q.st == ST_INIT);

    ps_half_tick #(.HALF(DIV_HALF)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tick_en),
        .tick_o (tick)
    );

    assign lost = !stat_s && ((r_q.st == ST_LOAD) || (r_q.st == ST_WDONE) ||
                              (r_q.st == ST_INIT));
    assign s_ready_o = (r_q.st == ST_LOAD) && (r_q.bits == '0) && stat_s;

    always_comb begin
        r_d = r_q;
        if (lost) begin
            // status dropped: flag and begin a fresh attempt
            r_d.st   = ST_RST;
            r_d.cnt  = '0;
            r_d.nrst = 1'b0;
            r_d.sclk = 1'b0;
            r_d.usr  = 1'b0;
            r_d.bits = '0;
            r_d.err  = 1'b1;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (start_i) begin
                        r_d.st   = ST_RST;
                        r_d.cnt  = '0;
                        r_d.nrst = 1'b0;
                        r_d.done = 1'b0;
                        r_d.err  = 1'b0;
                    end
                end
                ST_RST: begin
                    if (r_q.cnt == RST_LAST) begin
                        r_d.nrst = 1'b1;
                        r_d.st   = ST_WSTAT;
                        r_d.cnt  = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_WSTAT: begin
                    if (stat_s) begin
                        r_d.st   = ST_LOAD;
                        r_d.cnt  = '0;
                        r_d.bits = '0;
                    end else if (r_q.cnt == STAT_LAST) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_IDLE;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_LOAD: begin
                    if (r_q.bits == '0) begin
                        if (s_valid_i) begin
                            r_d.sh   = s_data_i;
                            r_d.bits = BITS_FULL;
                            r_d.last = s_last_i;
                            r_d.data = s_data_i[0];
                            r_d.sclk = 1'b0;
                        end
                    end else if (tick) begin
                        if (!r_q.sclk) begin
                            r_d.sclk = 1'b1;
                        end else begin
                            r_d.sclk = 1'b0;
                            r_d.sh   = r_q.sh >> 1;
                            r_d.data = r_q.sh[1];
                            r_d.bits = r_q.bits - 1'b1;
                            if ((r_q.bits == BITS_ONE) && r_q.last) begin
                                r_d.st  = ST_WDONE;
                                r_d.cnt = '0;
                            end
                        end
                    end
                end
                ST_WDONE: begin
                    if (done_s) begin
                        r_d.st  = ST_INIT;
                        r_d.cnt = '0;
                        r_d.usr = 1'b0;
                    end else if (r_q.cnt == DONE_LAST) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_IDLE;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_INIT: begin
                    if (tick) begin
                        if (!r_q.usr) begin
                            r_d.usr = 1'b1;
                            r_d.cnt = r_q.cnt + 1'b1;
                        end else begin
                            r_d.usr = 1'b0;
                            if (r_q.cnt == INIT_N) begin
                                r_d.st   = ST_IDLE;
                                r_d.done = 1'b1;
                            end
                        end
                    end
                end
                default: r_d = REGS_RST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign cfg_nrst_o = r_q.nrst;
    assign cfg_sclk_o = r_q.sclk;
    assign cfg_data_o = r_q.data;
    assign usr_clk_o  = r_q.usr;
    assign busy_o     = (r_q.st != ST_IDLE);
    assign done_o     = r_q.done;
    assign err_o      = r_q.err;

    // R1: the reset request is released only at the end of the timed pulse
    assert_rst_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.nrst) |-> ($past(r_q.st) == ST_RST))
        else $error("R1 reset request released outside the pulse phase");

    // R2: a serial rising edge needs the synchronized status line high
    assert_sclk_needs_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.sclk) |-> stat_s)
        else $error("R2 serial clock rose with status low");

    // R3: data holds across each serial rising edge
    assert_data_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.sclk) |-> $stable(r_q.data))
        else $error("R3 data moved on a serial rising edge");

    // R5: a byte is offered only with the serial clock parked low
    assert_ready_sclk_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> !r_q.sclk)
        else $error("R5 ready while serial clock high");

    // R6: start-up clock pulses occur only in the initialization phase
    assert_usr_in_init_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.usr) |-> (r_q.st == ST_INIT))
        else $error("R6 start-up clock outside initialization");

    // R7: a lost status line always leads to a new reset pulse with error set
    assert_restart_on_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> (!r_q.nrst && r_q.err))
        else $error("R7 no restart after status loss");
endmodule

// File: tb/tb_ps_cfg_master.sv
`timescale 1ns/1ps
module tb_ps_cfg_master;
    localparam int unsigned RST_CYC = 8000;
    localparam int unsigned INIT_N  = 299;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       s_valid = 1'b0;
    logic       s_last = 1'b0;
    logic       s_ready, nrst, sclk, sdata, usr, busy, done_f, err_f;
    logic       stat_line = 1'b1;
    logic       done_line = 1'b0;

    // bench-side controls for the target model
    logic       stat_en = 1'b1;
    logic       inject = 1'b0;
    logic       done_req = 1'b0;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ps_cfg_master #(
        .STAT_TIMEOUT(300),
        .DONE_TIMEOUT(300)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .s_data_i(s_data), .s_valid_i(s_valid), .s_last_i(s_last), .s_ready_o(s_ready),
        .cfg_nrst_o(nrst), .cfg_sclk_o(sclk), .cfg_data_o(sdata),
        .stat_i(stat_line), .done_i(done_line),
        .usr_clk_o(usr), .busy_o(busy), .done_o(done_f), .err_o(err_f)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // target model: status follows the reset request, done on request
    int rel_cnt = 0;
    always @(negedge clk) begin
        if (!nrst) begin
            stat_line = 1'b0;
            done_line = 1'b0;
            rel_cnt   = 0;
        end else begin
            if (inject) stat_line = 1'b0;
            else if (stat_en && !stat_line) begin
                rel_cnt++;
                if (rel_cnt >= 5) stat_line = 1'b1;
            end
            if (done_req) done_line = 1'b1;
        end
    end

    // monitor and scoreboard
    logic [7:0] exp_q[$];
    logic [7:0] cur = 8'h00;
    int   nbits = 0;
    int   sclk_rises = 0;
    int   usr_rises = 0;
    int   low_run = 0;
    int   last_low = 0;
    int   nrst_falls = 0;
    logic prev_sclk = 1'b0, prev_usr = 1'b0, prev_data = 1'b0, prev_nrst = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!nrst) begin
                low_run++;
                nbits = 0;
            end else if (!prev_nrst) begin
                last_low = low_run;
                low_run = 0;
            end
            if (prev_nrst && !nrst) nrst_falls++;
            if (sclk && !prev_sclk) begin
                sclk_rises++;
                chk(stat_line, "R2 serial edge with status low", 0, 1);
                chk(sdata == prev_data, "R3 data changed at rising edge", int'(sdata), int'(prev_data));
                cur = {sdata, cur[7:1]};
                nbits++;
                if (nbits == 8) begin
                    nbits = 0;
                    if (exp_q.size() == 0) chk(0, "R4 unexpected byte", int'(cur), -1);
                    else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(cur == e, "R4 byte order/LSB first", int'(cur), int'(e));
                    end
                end
            end
            if (s_ready && sclk) chk(0, "R5 ready with serial clock high", 1, 0);
            if (usr && !prev_usr) usr_rises++;
        end
        prev_sclk = sclk;
        prev_usr  = usr;
        prev_data = sdata;
        prev_nrst = nrst;
    end

    task automatic send_byte(input logic [7:0] b, input logic l);
        exp_q.push_back(b);
        @(negedge clk);
        s_data = b; s_valid = 1'b1; s_last = l;
        forever begin
            #1;
            if (s_ready) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_status_up();
        for (int i = 0; i < 20000 && !(nrst && stat_line && busy); i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 30000 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_drained();
        for (int i = 0; i < 2000 && (exp_q.size() != 0); i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int base_s, base_u, falls0;
        repeat (3) @(negedge clk);
        chk(nrst == 1'b1, "R10 reset-request idle high", int'(nrst), 1);
        chk(sclk == 1'b0, "R10 serial clock low", int'(sclk), 0);
        chk(usr == 1'b0, "R10 start-up clock low", int'(usr), 0);
        chk({busy, done_f, err_f, s_ready} == 4'b0, "R10 flags clear",
            int'({busy, done_f, err_f, s_ready}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Test A: full successful load
        pulse_start();
        chk(nrst == 1'b0 && busy, "R1 reset request asserted", int'(nrst), 0);
        wait_status_up();
        chk(last_low == RST_CYC, "R1 reset pulse width", last_low, RST_CYC);
        base_s = sclk_rises;
        repeat (40) @(negedge clk);
        chk(sclk_rises == base_s, "R5 serial clock idle without data", sclk_rises - base_s, 0);
        chk(s_ready == 1'b1, "R5 ready while empty", int'(s_ready), 1);
        send_byte(8'hA5, 1'b0);
        repeat (7) @(negedge clk);
        send_byte(8'h3C, 1'b0);
        send_byte(8'h01, 1'b1);
        wait_drained();
        chk(sclk_rises - base_s == 24, "R3 one rise per bit", sclk_rises - base_s, 24);
        chk(busy && !done_f, "R6 waiting for done line", int'(done_f), 0);
        base_u = usr_rises;
        done_req = 1'b1;
        wait_idle();
        chk(usr_rises - base_u == INIT_N, "R6 start-up clock count", usr_rises - base_u, INIT_N);
        chk(done_f && !err_f && !busy, "R6 success flags", int'({done_f, err_f, busy}), 4);
        done_req = 1'b0;

        // Test B: status never rises
        stat_en = 1'b0;
        pulse_start();
        wait_idle();
        chk(err_f == 1'b1, "R8 status timeout error", int'(err_f), 1);
        chk(!done_f && nrst, "R8 idle after timeout", int'({done_f, nrst}), 1);
        stat_en = 1'b1;

        // Test C: done never rises
        pulse_start();
        chk(err_f == 1'b0, "R7 error cleared by start", int'(err_f), 0);
        wait_status_up();
        send_byte(8'h96, 1'b1);
        wait_drained();
        wait_idle();
        chk(err_f && !done_f, "R9 done timeout error", int'({err_f, done_f}), 2);

        // Test D: status lost during initialization, then restart
        pulse_start();
        wait_status_up();
        send_byte(8'h5A, 1'b0);
        send_byte(8'hF0, 1'b1);
        wait_drained();
        done_req = 1'b1;
        for (int i = 0; i < 400 && (usr_rises - base_u) < INIT_N + 20; i++) @(negedge clk);
        falls0 = nrst_falls;
        inject = 1'b1; done_req = 1'b0;
        repeat (6) @(negedge clk);
        chk(nrst_falls == falls0 + 1, "R7 new reset pulse", nrst_falls - falls0, 1);
        chk(err_f && busy, "R7 error flagged and busy", int'({err_f, busy}), 3);
        inject = 1'b0;
        wait_status_up();
        chk(last_low == RST_CYC, "R7 restart pulse width", last_low, RST_CYC);
        send_byte(8'h81, 1'b0);
        send_byte(8'h7E, 1'b1);
        wait_drained();
        base_u = usr_rises;
        done_req = 1'b1;
        wait_idle();
        chk(usr_rises - base_u == INIT_N, "R6 start-up count after restart", usr_rises - base_u, INIT_N);
        chk(done_f && err_f, "R7 error sticky after success", int'({done_f, err_f}), 3);
        done_req = 1'b0;

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule